// File: doc/BRIEF.md
# Phase-Selectable SPI Bus Master

This block lets a host move bytes over a four-wire serial bus as the bus master. The host picks a bit rate and one of the four clock polarity/phase modes through a small mode register. It then writes bytes into a one-deep transmit holding register and collects received bytes from a receive data register. Two flags drive the handshake. One tells the host that another byte can be queued. The other tells it that a received byte is waiting to be read.

Inside the block, a prescaler keeps an internal serial clock running at all times. A control unit steps in step with that internal clock. It loads the transmit shift register and lets the clock reach the bus pin only while a byte is being moved. A byte queued during a transfer follows the current byte without a gap. The bus clock pin is registered, and the outgoing data bit is registered at the same point, so that both leave the block on the same system-clock edge.

Top module: `spi_phase_master`

## Requirements
- R1: After reset, sck and mosi are 0, txEmpty is 1, rxFull is 0 and rxData is 0.
- R2: A pulse on hostCtrlWr loads the mode from hostWdata. Bits [1:0] select a bus clock period of 4, 8, 16 or 32 system clocks (codes 0 to 3). Bit 2 is the idle level of sck. Bit 3 selects the clock phase: 0 samples on the first edge of each bit, 1 samples on the second edge.
- R3: While no byte is being moved, sck rests at the idle level from R2.
- R4: Each byte produces exactly 16 sck edges. Consecutive sampling edges within a transfer are exactly one bus clock period apart.
- R5: The transmitted byte appears on mosi most significant bit first. mosi is stable at every sampling edge. The sampling edge is rising when the idle level equals the phase bit, and falling otherwise.
- R6: miso is captured at each sampling edge, most significant bit first. After the eighth bit the byte appears on rxData.
- R7: rxFull goes to 1 when a received byte is placed in rxData. It returns to 0 in the cycle after a hostRxRd pulse.
- R8: txEmpty is 1 while the holding register is free. A hostTxWr pulse while txEmpty is 0 is dropped, and that byte is never sent.
- R9: A byte queued while a transfer is running starts right after the current byte. The sampling-edge spacing stays one bus clock period across the byte boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostCtrlWr | input | 1 | Mode register write strobe |
| hostTxWr | input | 1 | Transmit holding register write strobe |
| hostRxRd | input | 1 | Receive data read strobe; clears rxFull |
| hostWdata | input | 8 | Host write data |
| rxData | output | 8 | Last received byte |
| rxFull | output | 1 | A received byte is waiting |
| txEmpty | output | 1 | Holding register can accept a byte |
| sck | output | 1 | Bus clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench uses the default build: 8-bit bytes and a two-bit divider field, so the bus period runs from 4 to 32 system clocks. That configuration is small enough to sweep all sixteen mode and divider combinations. In each combination the bench sends two bytes back to back and offers a third byte that must be dropped. A slave model driven by the sck edges checks the bit order, the edge count and the spacing of the sampling edges, including across the byte boundary.

// File: rtl/spi_phase_pkg.sv
package spi_phase_pkg;
  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic load;    // fill transmit shifter from holding register
    logic shift;   // advance transmit shifter by one bit
    logic sample;  // capture miso (aligned with the registered sck edge)
    logic done;    // last bit captured, move byte to rxData
  } spiStrobe_t;
endpackage

// File: rtl/spi_phase_ctrl.sv
module spi_phase_ctrl
  import spi_phase_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int DIV_SEL_W     = 2,
  parameter int BASE_DIV_LOG2 = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ctrlWr,
  input  logic [DIV_SEL_W+1:0] ctrlData,
  input  logic                 txWr,
  output logic                 txEmpty,
  output spiStrobe_t           stb,
  output logic                 busLevel,
  output logic                 active,
  output logic                 cpol,
  output logic                 cpha
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam int CNT_W = BASE_DIV_LOG2 - 1 + (1 << DIV_SEL_W) - 1;

  logic [DIV_SEL_W-1:0] divSel;
  logic [CNT_W-1:0]     preCnt;
  logic [CNT_W:0]       halfLen;
  logic                 sckInt;
  logic                 wrap, riseEv, fallEv;
  logic                 txPend;
  logic [BIT_W-1:0]     bitCnt;
  logic                 lastBit;
  logic                 sampleQ, doneQ;
  logic                 mask0, mask1;

  // Mode register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divSel <= '0;
      cpol   <= 1'b0;
      cpha   <= 1'b0;
    end else if (ctrlWr) begin
      divSel <= ctrlData[DIV_SEL_W-1:0];
      cpol   <= ctrlData[DIV_SEL_W];
      cpha   <= ctrlData[DIV_SEL_W+1];
    end
  end

  // Free-running internal serial clock
  always_comb begin
    halfLen = {{CNT_W{1'b0}}, 1'b1} << (BASE_DIV_LOG2 - 1 + 32'(divSel));
    wrap    = ({1'b0, preCnt} + (CNT_W+1)'(1)) >= halfLen;
    riseEv  = wrap & ~sckInt;
    fallEv  = wrap & sckInt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
      sckInt <= 1'b0;
    end else if (wrap) begin
      preCnt <= '0;
      sckInt <= ~sckInt;
    end else begin
      preCnt <= preCnt + CNT_W'(1);
    end
  end

  // Control sequencing on internal clock events
  always_comb begin
    lastBit    = bitCnt == BIT_W'(DATA_W - 1);
    stb.load   = riseEv & txPend & (~active | lastBit);
    stb.shift  = riseEv & active & ~lastBit;
    stb.sample = sampleQ;
    stb.done   = doneQ;
    txEmpty    = ~txPend;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txPend  <= 1'b0;
      active  <= 1'b0;
      bitCnt  <= '0;
      sampleQ <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      if (stb.load)            txPend <= 1'b0;
      else if (txWr && !txPend) txPend <= 1'b1;

      if (stb.shift) begin
        bitCnt <= bitCnt + BIT_W'(1);
      end else if (stb.load) begin
        active <= 1'b1;
        bitCnt <= '0;
      end else if (riseEv && active) begin
        active <= 1'b0;
      end

      sampleQ <= fallEv & active;
      doneQ   <= fallEv & active & lastBit;
    end
  end

  // Clock masks for the two phase variants
  always_comb begin
    mask0    = active & ~sckInt;
    mask1    = active & sckInt;
    busLevel = (cpha ? mask1 : mask0) ^ cpol;
  end

  assert_txempty_fall_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txEmpty) |-> $past(txWr));

  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.sample |-> !stb.load);
endmodule

// File: rtl/spi_phase_dp.sv
module spi_phase_dp
  import spi_phase_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiStrobe_t        stb,
  input  logic              txWr,
  input  logic              txEmpty,
  input  logic [DATA_W-1:0] txData,
  input  logic              rdRx,
  input  logic              busLevel,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic [DATA_W-1:0] rxData,
  output logic              rxFull
);
  logic [DATA_W-1:0] txHold, txShift, rxShift;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txHold  <= '0;
      txShift <= '0;
      rxShift <= '0;
      rxData  <= '0;
      rxFull  <= 1'b0;
      sck     <= 1'b0;
      mosi    <= 1'b0;
    end else begin
      if (txWr && txEmpty) txHold <= txData;

      if (stb.load)       txShift <= txHold;
      else if (stb.shift) txShift <= {txShift[DATA_W-2:0], 1'b0};

      if (stb.sample) rxShift <= {rxShift[DATA_W-2:0], miso};

      if (stb.done) begin
        rxData <= {rxShift[DATA_W-2:0], miso};
        rxFull <= 1'b1;
      end else if (rdRx) begin
        rxFull <= 1'b0;
      end

      // Retime clock and data by the same single system clock
      sck  <= busLevel;
      mosi <= txShift[DATA_W-1];
    end
  end

  assert_rxfull_rise_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFull) |-> $past(stb.done));

  assert_rxfull_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rdRx) && !$past(stb.done)) |-> !rxFull);
endmodule

// File: rtl/spi_phase_master.sv
module spi_phase_master
  import spi_phase_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int DIV_SEL_W     = 2,
  parameter int BASE_DIV_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostCtrlWr,
  input  logic              hostTxWr,
  input  logic              hostRxRd,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] rxData,
  output logic              rxFull,
  output logic              txEmpty,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);
  spiStrobe_t stb;
  logic busLevel, active, cpol, cpha;

  spi_phase_ctrl #(
    .DATA_W(DATA_W), .DIV_SEL_W(DIV_SEL_W), .BASE_DIV_LOG2(BASE_DIV_LOG2)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .ctrlWr(hostCtrlWr),
    .ctrlData(hostWdata[DIV_SEL_W+1:0]), .txWr(hostTxWr),
    .txEmpty(txEmpty), .stb(stb), .busLevel(busLevel),
    .active(active), .cpol(cpol), .cpha(cpha)
  );

  spi_phase_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .txWr(hostTxWr), .txEmpty(txEmpty),
    .txData(hostWdata), .rdRx(hostRxRd), .busLevel(busLevel), .miso(miso),
    .sck(sck), .mosi(mosi), .rxData(rxData), .rxFull(rxFull)
  );

  assert_idle_level_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(active) && $stable(cpol)) |-> (sck == cpol));

  assert_mosi_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((sck != $past(sck)) && (sck == (cpol == cpha)) && $stable(cpol) && $past(active))
      |-> $stable(mosi));
endmodule

// File: tb/spi_phase_master_tb_top.sv
module spi_phase_master_tb_top;
  logic       clk = 1'b0;
  logic       rstN;
  logic       hostCtrlWr, hostTxWr, hostRxRd;
  logic [7:0] hostWdata;
  logic [7:0] rxData;
  logic       rxFull, txEmpty, sck, mosi;
  logic       miso = 1'b0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // Slave model state (written only by the monitor process)
  logic        prevSck = 1'b0;
  int          edgeCnt = 0, bitTot = 0, lastCyc = 0, gapErr = 0;
  logic [15:0] slaveRx = '0;
  int          armSeen = 0;
  // Written only by the stimulus process
  logic [7:0]  sTx [2];
  logic        sampleLvl = 1'b1;
  int          divNow = 4;
  int          armSeq = 0;

  always #2.5 clk = ~clk;

  spi_phase_master dut_i (
    .clk(clk), .rstN(rstN), .hostCtrlWr(hostCtrlWr), .hostTxWr(hostTxWr),
    .hostRxRd(hostRxRd), .hostWdata(hostWdata), .rxData(rxData),
    .rxFull(rxFull), .txEmpty(txEmpty), .sck(sck), .mosi(mosi), .miso(miso)
  );

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
      report();
    end
  end

  // Slave model: captures mosi on sampling edges, presents miso bits
  always @(negedge clk) begin
    if (armSeq != armSeen) begin
      armSeen = armSeq;
      edgeCnt = 0; bitTot = 0; gapErr = 0; slaveRx = '0;
      miso    = sTx[0][7];
      prevSck = sck;
    end else if (sck !== prevSck) begin
      edgeCnt++;
      if (sck == sampleLvl) begin
        slaveRx = {slaveRx[14:0], mosi};
        if (bitTot > 0 && (cyc - lastCyc) != divNow) gapErr++;
        lastCyc = cyc;
        bitTot++;
        if (bitTot < 16) miso = sTx[bitTot / 8][7 - (bitTot % 8)];
      end
      prevSck = sck;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic pulseTx(logic [7:0] d);
    hostTxWr = 1'b1; hostWdata = d;
    @(negedge clk);
    hostTxWr = 1'b0;
  endtask

  initial begin
    rstN = 1'b0; hostCtrlWr = 1'b0; hostTxWr = 1'b0; hostRxRd = 1'b0; hostWdata = '0;
    sTx[0] = '0; sTx[1] = '0;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(sck == 1'b0 && mosi == 1'b0, "R1", "sck/mosi at reset", {sck, mosi}, 0);
    check(txEmpty == 1'b1 && rxFull == 1'b0, "R1", "flags at reset", {txEmpty, rxFull}, 2);
    check(rxData == 8'h00, "R1", "rxData at reset", rxData, 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int cfg = 0; cfg < 16; cfg++) begin
      logic [1:0] dSel;
      logic       pol, pha;
      logic [7:0] mA, mB, mC;
      dSel = cfg[1:0]; pol = cfg[2]; pha = cfg[3];
      // R2 mode write
      hostCtrlWr = 1'b1; hostWdata = {4'b0, pha, pol, dSel};
      @(negedge clk);
      hostCtrlWr = 1'b0;
      repeat (3) @(negedge clk);
      check(sck == pol, "R3", "idle sck level", sck, pol);

      sampleLvl = (pol == pha);
      divNow    = 4 << dSel;
      sTx[0]    = 8'h3C ^ 8'(cfg * 37);
      sTx[1]    = 8'hC1 + 8'(cfg * 11);
      mA        = 8'hA5 ^ 8'(cfg * 17);
      mB        = 8'h5A + 8'(cfg * 29);
      mC        = ~mB;
      armSeq++;
      @(negedge clk);

      pulseTx(mA);
      while (!txEmpty) @(negedge clk);
      pulseTx(mB);
      check(txEmpty == 1'b0, "R8", "txEmpty after queueing", txEmpty, 0);
      pulseTx(mC); // must be dropped (R8)

      while (!rxFull) @(negedge clk);
      check(rxData == sTx[0], "R6", "first received byte", rxData, sTx[0]);
      hostRxRd = 1'b1;
      @(negedge clk);
      hostRxRd = 1'b0;
      check(rxFull == 1'b0, "R7", "rxFull after read", rxFull, 0);

      while (!rxFull) @(negedge clk);
      check(rxData == sTx[1], "R6", "second received byte", rxData, sTx[1]);
      hostRxRd = 1'b1;
      @(negedge clk);
      hostRxRd = 1'b0;

      repeat (2 * divNow + 6) @(negedge clk);
      check(bitTot == 16, "R8", "bits sent (dropped write)", bitTot, 16);
      check(slaveRx == {mA, mB}, "R5", "bytes seen by slave", slaveRx, {mA, mB});
      check(edgeCnt == 32, "R4", "sck edges for two bytes", edgeCnt, 32);
      check(gapErr == 0, "R2 R4 R9", "sampling edge spacing errors", gapErr, 0);
      check(sck == pol, "R3", "sck back at idle", sck, pol);
      check(rxFull == 1'b0 && txEmpty == 1'b1, "R8", "no third byte", {rxFull, txEmpty}, 1);
    end
    report();
  end
endmodule